// File: doc/BRIEF.md
# Sliding-Window Ordered-Statistic Sorter

This block holds the most recent samples of a power stream in descending order, so that an ordered-statistic detector can read the k-th largest value of a reference window at any time. Every accepted sample is placed at its sorted position. Once the window holds its configured number of samples, the sample that arrived earliest leaves in the same step. Departure therefore follows arrival age and not value, and the sorted array behaves as a sliding window over the stream.

The window length and the rank that is read out are both run-time inputs. The length can be any value from one up to a compile-time maximum, which need not be a power of two. A detector usually uses two instances, one for the leading reference cells and one for the lagging ones. A frame ends with a last-flagged sample. After that sample is inserted, the window empties itself so that the next frame starts clean.

Top module: `win_sorter`

## Requirements
- R1: Valid entries are kept in descending order. `stat_o` shows the entry at position `rank_i`, where rank 0 is the largest value. A rank at or above the number of held samples, including any rank of MAX_N or more, shows 0.
- R2: While `in_ready_o` is high, one sample is accepted on each clock edge where `in_valid_i` is high. The held contents and `stat_o` reflect that sample from the cycle after the handshake.
- R3: Until the window holds the configured number of samples, no sample is removed and `full_o` stays low. `full_o` is high while the held count equals the configured size.
- R4: When the window is full, each accepted sample removes the sample that arrived earliest. The contents are then exactly the latest `size` samples of the frame.
- R5: `win_size_i` is sampled only while the window is empty, so changing it while samples are held has no effect until the next frame. A value of 0 acts as 1, and a value above MAX_N acts as MAX_N.
- R6: In the cycle after a last-flagged sample is accepted, `in_ready_o` is low, no input is accepted, and the contents still include that sample. One cycle later the window is empty, `full_o` is low and `in_ready_o` is high.
- R7: After reset the window is empty, `full_o` is low, `stat_o` is 0 and `in_ready_o` is high.
- R8: `rank_i` selects the output combinationally. A new rank is visible in the same cycle, with no sample accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input sample valid |
| in_ready_o | output | 1 | Sorter can accept a sample |
| in_data_i | input | DATA_W | Input power sample (unsigned) |
| in_last_i | input | 1 | Marks the final sample of a frame |
| win_size_i | input | CNT_W | Requested window length |
| rank_i | input | CNT_W | Sorted position to present |
| stat_o | output | DATA_W | Ordered-statistic value at `rank_i` |
| full_o | output | 1 | Window holds the configured number of samples |

## Verification
Insertion and removal of the oldest sample fall in the same cycle once the window is full. The removed cell may sit above, below or at the new sample's sorted position, and a tie with the new value is possible. These cases are provoked by sweeping every window length from 1 to MAX_N with low-range pseudo-random data, so ties and every relative position occur. After each sample, every rank is compared against a bench model that sorts the last `size` samples of the frame. A second collision, a last-flagged sample followed at once by another valid sample, is judged by checking that the extra sample never appears and that the window is empty afterwards.

// File: rtl/win_sorter_pkg.sv
package win_sorter_pkg;
  typedef enum logic {
    PH_RUN   = 1'b0,
    PH_FLUSH = 1'b1
  } phase_e;
endpackage

// File: rtl/win_sorter_evict_sel.sv
module win_sorter_evict_sel #(
  parameter int MAX_N = 16,
  parameter int CNT_W = $clog2(MAX_N + 1)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [MAX_N-1:0]               vld_i,
  input  logic [MAX_N-1:0][CNT_W-1:0]    age_i,
  input  logic [CNT_W-1:0]               target_i,
  output logic                           hit_o,
  output logic [CNT_W-1:0]               idx_o
);
  logic [MAX_N-1:0] match;

  for (genvar i = 0; i < MAX_N; i++) begin : g_match
    assign match[i] = vld_i[i] && (age_i[i] == target_i);
  end

  assign hit_o = |match;

  always_comb begin
    idx_o = CNT_W'(MAX_N);
    for (int i = MAX_N - 1; i >= 0; i--) begin
      if (match[i]) idx_o = CNT_W'(i);
    end
  end

  // R4
  evict_unique_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match));
endmodule

// File: rtl/win_sorter_next.sv
module win_sorter_next #(
  parameter int DATA_W = 16,
  parameter int MAX_N  = 16,
  parameter int CNT_W  = $clog2(MAX_N + 1)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [MAX_N-1:0][DATA_W-1:0]   val_i,
  input  logic [MAX_N-1:0][CNT_W-1:0]    age_i,
  input  logic [MAX_N-1:0]               vld_i,
  input  logic                           evict_en_i,
  input  logic [CNT_W-1:0]               evict_idx_i,
  input  logic [DATA_W-1:0]              din_i,
  output logic [MAX_N-1:0][DATA_W-1:0]   val_o,
  output logic [MAX_N-1:0][CNT_W-1:0]    age_o,
  output logic [MAX_N-1:0]               vld_o
);
  logic [MAX_N:0][DATA_W-1:0] ext_val;
  logic [MAX_N:0][CNT_W-1:0]  ext_age;
  logic [MAX_N:0]             ext_vld;
  logic [MAX_N-1:0][DATA_W-1:0] rem_val;
  logic [MAX_N-1:0][CNT_W-1:0]  rem_age;
  logic [MAX_N-1:0]             rem_vld;
  logic [MAX_N-1:0]             rem_ge;
  logic [CNT_W-1:0]             ins_pos;

  assign ext_val = {DATA_W'(0), val_i};
  assign ext_age = {CNT_W'(0), age_i};
  assign ext_vld = {1'b0, vld_i};

  // stage 1: close the gap left by the evicted cell
  for (genvar j = 0; j < MAX_N; j++) begin : g_rem
    logic up;
    assign up         = evict_en_i && (CNT_W'(j) >= evict_idx_i);
    assign rem_val[j] = up ? ext_val[j+1] : ext_val[j];
    assign rem_age[j] = up ? ext_age[j+1] : ext_age[j];
    assign rem_vld[j] = up ? ext_vld[j+1] : ext_vld[j];
    // ties: new sample goes after existing equal entries
    assign rem_ge[j]  = rem_vld[j] && (rem_val[j] >= din_i);
  end

  assign ins_pos = CNT_W'($countones(rem_ge));

  // stage 2: open a slot at the insertion point
  for (genvar j = 0; j < MAX_N; j++) begin : g_ins
    if (j == 0) begin : g_head
      always_comb begin
        if (ins_pos == '0) begin
          val_o[j] = din_i;
          age_o[j] = '0;
          vld_o[j] = 1'b1;
        end else begin
          val_o[j] = rem_val[j];
          age_o[j] = rem_vld[j] ? rem_age[j] + 1'b1 : '0;
          vld_o[j] = rem_vld[j];
        end
      end
    end else begin : g_body
      always_comb begin
        if (CNT_W'(j) < ins_pos) begin
          val_o[j] = rem_val[j];
          age_o[j] = rem_vld[j] ? rem_age[j] + 1'b1 : '0;
          vld_o[j] = rem_vld[j];
        end else if (CNT_W'(j) == ins_pos) begin
          val_o[j] = din_i;
          age_o[j] = '0;
          vld_o[j] = 1'b1;
        end else begin
          val_o[j] = rem_val[j-1];
          age_o[j] = rem_vld[j-1] ? rem_age[j-1] + 1'b1 : '0;
          vld_o[j] = rem_vld[j-1];
        end
      end
    end
  end

  for (genvar j = 0; j + 1 < MAX_N; j++) begin : g_chk
    // R1
    ge_prefix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rem_ge[j+1] |-> rem_ge[j]);
  end
endmodule

// File: rtl/win_sorter_rank_mux.sv
module win_sorter_rank_mux #(
  parameter int DATA_W = 16,
  parameter int MAX_N  = 16,
  parameter int CNT_W  = $clog2(MAX_N + 1)
) (
  input  logic [MAX_N-1:0][DATA_W-1:0] val_i,
  input  logic [CNT_W-1:0]             rank_i,
  output logic [DATA_W-1:0]            stat_o
);
  always_comb begin
    stat_o = '0;
    for (int i = 0; i < MAX_N; i++) begin
      if (rank_i == CNT_W'(i)) stat_o = val_i[i];
    end
  end
endmodule

// File: rtl/win_sorter.sv
module win_sorter #(
  parameter int DATA_W = 16,
  parameter int MAX_N  = 16,
  parameter int CNT_W  = $clog2(MAX_N + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_last_i,
  input  logic [CNT_W-1:0]  win_size_i,
  input  logic [CNT_W-1:0]  rank_i,
  output logic [DATA_W-1:0] stat_o,
  output logic              full_o
);
  import win_sorter_pkg::*;

  localparam logic [CNT_W-1:0] MAX_SZ = CNT_W'(MAX_N);

  logic [MAX_N-1:0][DATA_W-1:0] val_q, val_d;
  logic [MAX_N-1:0][CNT_W-1:0]  age_q, age_d;
  logic [MAX_N-1:0]             vld_q, vld_d;
  logic [CNT_W-1:0]             cnt_q, size_q, req_size, eff_size, ev_idx;
  phase_e                       phase_q;
  logic                         hs, evict_en, ev_hit;

  assign req_size   = (win_size_i == '0) ? CNT_W'(1) :
                      (win_size_i > MAX_SZ) ? MAX_SZ : win_size_i;
  assign eff_size   = (cnt_q == '0) ? req_size : size_q;
  assign evict_en   = (cnt_q != '0) && (cnt_q == eff_size);
  assign in_ready_o = (phase_q == PH_RUN);
  assign hs         = in_valid_i && in_ready_o;
  assign full_o     = (cnt_q != '0) && (cnt_q == size_q);

  win_sorter_evict_sel #(.MAX_N(MAX_N), .CNT_W(CNT_W)) u_evict (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vld_i    (vld_q),
    .age_i    (age_q),
    .target_i (eff_size - 1'b1),
    .hit_o    (ev_hit),
    .idx_o    (ev_idx)
  );

  win_sorter_next #(.DATA_W(DATA_W), .MAX_N(MAX_N), .CNT_W(CNT_W)) u_next (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .val_i       (val_q),
    .age_i       (age_q),
    .vld_i       (vld_q),
    .evict_en_i  (evict_en),
    .evict_idx_i (ev_idx),
    .din_i       (in_data_i),
    .val_o       (val_d),
    .age_o       (age_d),
    .vld_o       (vld_d)
  );

  win_sorter_rank_mux #(.DATA_W(DATA_W), .MAX_N(MAX_N), .CNT_W(CNT_W)) u_mux (
    .val_i  (val_q),
    .rank_i (rank_i),
    .stat_o (stat_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q   <= '0;
      age_q   <= '0;
      vld_q   <= '0;
      cnt_q   <= '0;
      size_q  <= MAX_SZ;
      phase_q <= PH_RUN;
    end else if (phase_q == PH_FLUSH) begin
      val_q   <= '0;
      age_q   <= '0;
      vld_q   <= '0;
      cnt_q   <= '0;
      phase_q <= PH_RUN;
    end else begin
      if (cnt_q == '0) size_q <= req_size;
      if (hs) begin
        val_q <= val_d;
        age_q <= age_d;
        vld_q <= vld_d;
        if (!evict_en) cnt_q <= cnt_q + 1'b1;
        if (in_last_i) phase_q <= PH_FLUSH;
      end
    end
  end

  // R1
  for (genvar i = 0; i + 1 < MAX_N; i++) begin : g_ord
    desc_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_q[i+1] |-> (vld_q[i] && val_q[i] >= val_q[i+1]));
  end

  // R2
  fill_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs && !evict_en) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R3
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> (cnt_q <= size_q));

  // R4
  evict_found_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_en |-> ev_hit);

  // R4
  evict_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs && evict_en) |=> (cnt_q == $past(cnt_q) && full_o));

  // R5
  size_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |=> $stable(size_q));

  // R6
  flush_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs && in_last_i) |=> !in_ready_o);

  // R6
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_FLUSH) |=> (cnt_q == '0 && in_ready_o));
endmodule

// File: tb/win_sorter_tb.sv
module win_sorter_tb_top;
  localparam int DW = 16;
  localparam int MN = 16;
  localparam int CW = $clog2(MN + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0, in_last = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [CW-1:0] win_size = CW'(MN), rank = '0;
  logic          in_ready, full;
  logic [DW-1:0] stat;

  int n_chk = 0, n_fail = 0;
  int fr[$];
  int sz_lat = MN;
  int lfsr = 32'h1d3a;

  always #2 clk = ~clk;

  win_sorter #(.DATA_W(DW), .MAX_N(MN)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_data_i(in_data), .in_last_i(in_last), .win_size_i(win_size),
    .rank_i(rank), .stat_o(stat), .full_o(full)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clamp_sz(int s);
    if (s == 0) return 1;
    if (s > MN) return MN;
    return s;
  endfunction

  function automatic int win_len();
    return (fr.size() < sz_lat) ? fr.size() : sz_lat;
  endfunction

  function automatic int exp_rank(int r);
    int t[MN];
    int n = win_len();
    for (int i = 0; i < n; i++) t[i] = fr[fr.size() - n + i];
    for (int i = 1; i < n; i++)
      for (int j = i; j > 0 && t[j] > t[j-1]; j--) begin
        int x = t[j]; t[j] = t[j-1]; t[j-1] = x;
      end
    return (r < n) ? t[r] : 0;
  endfunction

  function automatic int next_val();
    lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hb400 : 0);
    return ((lfsr & 15) == 3) ? (lfsr & 16'hffff) : (lfsr & 7);
  endfunction

  task automatic model_push(int d);
    if (fr.size() == 0) sz_lat = clamp_sz(int'(win_size));
    fr.push_back(d);
  endtask

  task automatic push(int d, bit last);
    @(negedge clk);
    in_valid = 1'b1; in_data = DW'(d); in_last = last;
    @(posedge clk);
    #1 in_valid = 1'b0; in_last = 1'b0;
    model_push(d);
  endtask

  // R1 R8: sweep ranks with no new sample
  task automatic sweep_ranks(string req);
    for (int r = 0; r < MN + 2; r++) begin
      @(negedge clk);
      rank = CW'(r);
      #1 check(req, int'(stat), exp_rank(r));
    end
  endtask

  // R6: expects the last push to have just happened
  task automatic check_flush();
    @(negedge clk);
    rank = '0;
    #0.5 check("R6 stall", int'(in_ready), 0);
    check("R6 held", int'(stat), exp_rank(0));
    @(negedge clk);
    fr.delete();
    #0.5 check("R6 empty", int'(stat), 0);
    check("R6 full", int'(full), 0);
    check("R6 ready", int'(in_ready), 1);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #9 rst_n = 1'b1;
    @(negedge clk);
    check("R7 ready", int'(in_ready), 1);
    check("R7 full", int'(full), 0);
    check("R7 stat", int'(stat), 0);

    // R4 R3: every size, evictions colliding with insertions at all positions
    for (int s = 1; s <= MN; s++) begin
      win_size = CW'(s);
      for (int k = 0; k < 2 * s + 3; k++) begin
        push(next_val(), k == 2 * s + 2);
        if (k < 2 * s + 2) begin
          @(negedge clk);
          check("R3 full", int'(full), (fr.size() >= sz_lat) ? 1 : 0);
          sweep_ranks("R4 rank");
        end
      end
      check_flush();
    end

    // R2: back-to-back stream
    win_size = CW'(5);
    rank = CW'(2);
    for (int k = 0; k < 14; k++) begin
      @(negedge clk);
      if (k > 0) check("R2 stream", int'(stat), exp_rank(2));
      in_valid = 1'b1; in_data = DW'(next_val()); in_last = (k == 13);
      model_push(int'(in_data));
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    #0.5 check("R2 stream end", int'(stat), exp_rank(2));
    @(negedge clk);
    fr.delete();
    #0.5 check("R2 cleared", int'(stat), 0);

    // R5: size change while holding data is ignored
    win_size = CW'(6);
    for (int k = 0; k < 3; k++) push(next_val(), 1'b0);
    win_size = CW'(2);
    for (int k = 0; k < 5; k++) push(10 + k, 1'b0);
    @(negedge clk);
    check("R5 full", int'(full), 1);
    sweep_ranks("R5 hold");
    push(7, 1'b1);
    check_flush();
    for (int k = 0; k < 4; k++) push(20 + k, 1'b0);
    @(negedge clk);
    check("R5 new size full", int'(full), 1);
    sweep_ranks("R5 new size");
    push(1, 1'b1);
    check_flush();

    // R5: zero acts as one, oversize acts as MAX_N
    win_size = '0;
    push(4, 1'b0);
    @(negedge clk);
    check("R5 zero full", int'(full), 1);
    push(9, 1'b0);
    sweep_ranks("R5 zero");
    push(2, 1'b1);
    check_flush();
    win_size = CW'(20);
    for (int k = 0; k < MN + 2; k++) begin
      push(next_val(), 1'b0);
      @(negedge clk);
      check("R5 clamp full", int'(full), (k >= MN - 1) ? 1 : 0);
    end
    sweep_ranks("R5 clamp");

    // R6: sample offered during the flush cycle is refused
    @(negedge clk);
    in_valid = 1'b1; in_data = DW'(50); in_last = 1'b1;
    @(posedge clk);
    model_push(50);
    @(negedge clk);
    in_data = DW'(999); in_last = 1'b0;
    #0.5 check("R6 stall", int'(in_ready), 0);
    rank = '0;
    #0.5 check("R6 held", int'(stat), exp_rank(0));
    @(negedge clk);
    in_valid = 1'b0;
    fr.delete();
    #0.5 check("R6 refused", int'(stat), 0);
    check("R6 refused full", int'(full), 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule